// File: doc/BRIEF.md
# Predicate Mask Fetch Controller

This block produces a source mask and a destination mask for an instruction that loops over vector elements. A request arrives over a valid/ready handshake. It carries a predicate mode, a 3-bit source selector, a 3-bit destination selector, a vector length and a base condition-field number. The block then works out which register reads the masks need and drives them on two narrow read ports, one for the integer register file and one for the condition-field file. Both ports return data one clock after the enable.

In integer mode, each selector names one of three fixed integer registers. The register value is used as it is, bitwise complemented, or turned into a single set bit at the position the value gives. The source read is issued before the destination read. In condition mode, one 4-bit field is read per vector element. Each read supplies one bit to the source mask and one bit to the destination mask. When both masks are complete, the block presents them on a second valid/ready handshake and holds them until the consumer takes them.

Top module: `pred_mask_fetch`

## Requirements
- R1: After reset, `req_ready` is 1, `msk_valid` is 0, both masks are 0 and neither read enable is asserted.
- R2: `req_ready` is 1 only while idle, and a request is taken when `req_valid` and `req_ready` are both 1. From acceptance until the result is taken, `req_ready` stays 0 and no read enable is asserted while idle.
- R3: Once `msk_valid` rises, it and both masks hold until `msk_ready` is seen. In the cycle after that handshake, `req_ready` is 1 and `msk_valid` is 0.
- R4: Mode code 0 (no predication) and mode code 3 (treated the same way) give all-ones source and destination masks and perform no register read.
- R5: In integer mode (mode code 1), the selector codes decode as follows. Code 0 gives all ones with no read. Codes 2 and 3 use register 3, codes 4 and 5 use register 10, and codes 6 and 7 use register 30. An even code takes the value directly and an odd code takes its bitwise complement.
- R6: In integer mode, selector code 1 reads register 3 and gives a mask with exactly one set bit, at the position given by the low 6 bits of the value read.
- R7: In integer mode, the source register read (if any) is issued before the destination register read (if any). Each read lasts one enable cycle, and a read is issued only for a selector that is not code 0.
- R8: In condition mode (mode code 2), a selector uses field bit `sel[2:1]`, where field bit k is `cr_rdata[k]`. An even code marks an element active when that bit is 1, and an odd code marks it active when the bit is 0.
- R9: In condition mode, the block reads fields `(base + i) mod 128` for i = 0 up to min(vl, 64) - 1, in increasing order, one per enable. Mask bit i is set when element i is active, and every mask bit at or above the clamped length is 0. A length of 0 gives no read and zero masks.
- R10: The mask outputs change only in the cycle the result becomes valid. They stay unchanged through the result handshake, while idle, and while the next request is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_mode | input | 2 | Predicate mode: 0 none, 1 integer, 2 condition, 3 none |
| req_src_sel | input | 3 | Source selector code |
| req_dst_sel | input | 3 | Destination selector code |
| req_vlen | input | 7 | Vector length, clamped to 64 |
| req_cr_base | input | 7 | First condition field number |
| int_ren | output | 1 | Integer register read enable |
| int_raddr | output | 5 | Integer register number |
| int_rdata | input | 64 | Integer read data, one cycle after enable |
| cr_ren | output | 1 | Condition field read enable |
| cr_raddr | output | 7 | Condition field number |
| cr_rdata | input | 4 | Condition field data, one cycle after enable |
| msk_valid | output | 1 | Masks valid |
| msk_ready | input | 1 | Consumer takes the masks |
| src_mask | output | 64 | Source element mask |
| dst_mask | output | 64 | Destination element mask |

## Verification
The bench targets the selector corner cases. It covers code 0 inside integer mode: a design that read a register there would show an extra read in the log. It also covers the unary code with a register value above 63: a design that did not wrap the position would return zero or more than one set bit. Condition runs use length 0, lengths above 64 and bases near 127. A loop off by one, an unclamped length or a missing address wrap would show up as a wrong read count, a wrong address sequence, or stray high mask bits. Each odd and even code pair is exercised so that a swapped polarity or a wrong bit index changes the mask. Random stalls on `msk_ready` expose a result that drops early or changes while it is held.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  localparam int SEL_W = 3;
  localparam int FLD_W = 4;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INT  = 2'd1,
    PM_CR   = 2'd2,
    PM_RSVD = 2'd3
  } pmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT_SRC,
    ST_INT_DST,
    ST_CR_RUN,
    ST_FIN,
    ST_DONE
  } pst_e;

  // one selector seen both as integer and as condition selector
  typedef struct packed {
    logic       need_rd;  // integer view: register read required
    logic [1:0] reg_slot; // 0,1,2 -> three fixed registers
    logic       invert;
    logic       unary;
    logic [1:0] fbit;     // condition view: bit within field
    logic       want_set; // condition view: required polarity
  } sel_dec_t;

endpackage

// File: rtl/pmf_sel_dec.sv
module pmf_sel_dec
  import pmf_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output sel_dec_t         dec
);

  always_comb begin
    dec          = '0;
    dec.fbit     = sel[2:1];
    dec.want_set = ~sel[0];
    unique case (sel)
      3'd0: dec.need_rd = 1'b0;
      3'd1: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd0; dec.unary = 1'b1; end
      3'd2: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd0; end
      3'd3: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd0; dec.invert = 1'b1; end
      3'd4: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd1; end
      3'd5: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd1; dec.invert = 1'b1; end
      3'd6: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd2; end
      default: begin dec.need_rd = 1'b1; dec.reg_slot = 2'd2; dec.invert = 1'b1; end
    endcase
  end

endmodule

// File: rtl/pmf_mask_asm.sv
module pmf_mask_asm
  import pmf_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_evt,
  input  logic              init_ones,
  input  logic              is_int,
  input  sel_dec_t          src_dec,
  input  sel_dec_t          dst_dec,
  input  logic              cap_int,
  input  logic              cap_to_dst,
  input  logic [MASK_W-1:0] int_rdata,
  input  logic              cap_cr,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [FLD_W-1:0]  cr_rdata,
  input  logic              load_evt,
  output logic [MASK_W-1:0] src_mask,
  output logic [MASK_W-1:0] dst_mask
);

  logic [MASK_W-1:0] src_w, dst_w;
  logic              src_hit, dst_hit;

  function automatic logic [MASK_W-1:0] shape_int(input sel_dec_t d,
                                                  input logic [MASK_W-1:0] v);
    logic [MASK_W-1:0] one;
    one = {{(MASK_W-1){1'b0}}, 1'b1};
    if (d.unary)       return one << v[IDX_W-1:0];
    else if (d.invert) return ~v;
    else               return v;
  endfunction

  function automatic logic field_hit(input sel_dec_t d, input logic [FLD_W-1:0] f);
    return f[d.fbit] == d.want_set;
  endfunction

  assign src_hit = field_hit(src_dec, cr_rdata);
  assign dst_hit = field_hit(dst_dec, cr_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_w <= '0;
      dst_w <= '0;
    end else if (init_evt) begin
      src_w <= init_ones ? '1 : '0;
      dst_w <= init_ones ? '1 : '0;
    end else begin
      if (cap_int && !cap_to_dst) src_w <= shape_int(src_dec, int_rdata);
      if (cap_int &&  cap_to_dst) dst_w <= shape_int(dst_dec, int_rdata);
      if (cap_cr) begin
        src_w[cap_idx] <= src_hit;
        dst_w[cap_idx] <= dst_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_mask <= '0;
      dst_mask <= '0;
    end else if (load_evt) begin
      src_mask <= src_w;
      dst_mask <= dst_w;
    end
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(src_mask) && $stable(dst_mask)); // R10

  AST_UNARY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && is_int && src_dec.unary |=> $countones(src_mask) == 1); // R6

endmodule

// File: rtl/pred_mask_fetch.sv
module pred_mask_fetch
  import pmf_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int IREG_W = 5,
  parameter int CR_AW  = 7,
  parameter int REG_P  = 3,
  parameter int REG_Q  = 10,
  parameter int REG_R  = 30,
  localparam int IDX_W = $clog2(MASK_W),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [SEL_W-1:0]  req_src_sel,
  input  logic [SEL_W-1:0]  req_dst_sel,
  input  logic [VL_W-1:0]   req_vlen,
  input  logic [CR_AW-1:0]  req_cr_base,
  output logic              int_ren,
  output logic [IREG_W-1:0] int_raddr,
  input  logic [MASK_W-1:0] int_rdata,
  output logic              cr_ren,
  output logic [CR_AW-1:0]  cr_raddr,
  input  logic [FLD_W-1:0]  cr_rdata,
  output logic              msk_valid,
  input  logic              msk_ready,
  output logic [MASK_W-1:0] src_mask,
  output logic [MASK_W-1:0] dst_mask
);

  pst_e              st_q, st_d;
  pmode_e            mode_q;
  logic [SEL_W-1:0]  sel_q [2];
  sel_dec_t          dec   [2];
  logic [VL_W-1:0]   vl_q, vl_in;
  logic [VL_W-1:0]   cnt_q;
  logic [CR_AW-1:0]  base_q;
  logic              pend_q, pend_dst_q;
  logic [IDX_W-1:0]  pend_idx_q;

  // named internal events
  logic acc_evt, load_evt, give_evt, rd_src, rd_dst;

  assign req_ready = (st_q == ST_IDLE);
  assign msk_valid = (st_q == ST_DONE);
  assign acc_evt   = req_valid && req_ready;
  assign load_evt  = (st_q == ST_FIN) && !pend_q;
  assign give_evt  = msk_valid && msk_ready;

  assign vl_in = (req_vlen > VL_W'(MASK_W)) ? VL_W'(MASK_W) : req_vlen;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    pmf_sel_dec u_dec (.sel(sel_q[g]), .dec(dec[g]));
  end

  function automatic logic [IREG_W-1:0] slot_reg(input logic [1:0] s);
    case (s)
      2'd0:    return IREG_W'(REG_P);
      2'd1:    return IREG_W'(REG_Q);
      default: return IREG_W'(REG_R);
    endcase
  endfunction

  assign rd_src    = (st_q == ST_INT_SRC) && dec[0].need_rd;
  assign rd_dst    = (st_q == ST_INT_DST) && dec[1].need_rd;
  assign int_ren   = rd_src || rd_dst;
  assign int_raddr = slot_reg(rd_dst ? dec[1].reg_slot : dec[0].reg_slot);

  assign cr_ren    = (st_q == ST_CR_RUN) && (cnt_q < vl_q);
  assign cr_raddr  = base_q + CR_AW'(cnt_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        case (pmode_e'(req_mode))
          PM_INT:  st_d = ST_INT_SRC;
          PM_CR:   st_d = ST_CR_RUN;
          default: st_d = ST_FIN;
        endcase
      end
      ST_INT_SRC: st_d = ST_INT_DST;
      ST_INT_DST: st_d = ST_FIN;
      ST_CR_RUN:  if (!cr_ren) st_d = ST_FIN;
      ST_FIN:     if (!pend_q) st_d = ST_DONE;
      ST_DONE:    if (msk_ready) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= PM_NONE;
      sel_q[0]   <= '0;
      sel_q[1]   <= '0;
      vl_q       <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_dst_q <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      st_q       <= st_d;
      pend_q     <= int_ren || cr_ren;
      pend_dst_q <= rd_dst;
      pend_idx_q <= cnt_q[IDX_W-1:0];
      if (acc_evt) begin
        mode_q   <= pmode_e'(req_mode);
        sel_q[0] <= req_src_sel;
        sel_q[1] <= req_dst_sel;
        vl_q     <= vl_in;
        base_q   <= req_cr_base;
        cnt_q    <= '0;
      end else if (cr_ren) begin
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  pmf_mask_asm #(.MASK_W(MASK_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_evt   (acc_evt),
    .init_ones  (pmode_e'(req_mode) != PM_CR),
    .is_int     (mode_q == PM_INT),
    .src_dec    (dec[0]),
    .dst_dec    (dec[1]),
    .cap_int    (pend_q && (mode_q == PM_INT)),
    .cap_to_dst (pend_dst_q),
    .int_rdata  (int_rdata),
    .cap_cr     (pend_q && (mode_q == PM_CR)),
    .cap_idx    (pend_idx_q),
    .cr_rdata   (cr_rdata),
    .load_evt   (load_evt),
    .src_mask   (src_mask),
    .dst_mask   (dst_mask)
  );

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && msk_valid)); // R2

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !int_ren && !cr_ren); // R2

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msk_valid && !msk_ready |=> msk_valid); // R3

  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    give_evt |=> req_ready); // R3

  AST_NONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && !req_mode[0] && !req_mode[1] |=> !int_ren && !cr_ren); // R4

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ren && cr_ren)); // R7

  AST_CR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    cr_ren && $past(cr_ren) |-> cr_raddr == $past(cr_raddr) + 1'b1); // R9

endmodule

// File: tb/pred_mask_fetch_tb.sv
module pred_mask_fetch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_mode = '0;
  logic [2:0]  req_src_sel = '0;
  logic [2:0]  req_dst_sel = '0;
  logic [6:0]  req_vlen = '0;
  logic [6:0]  req_cr_base = '0;
  logic        int_ren;
  logic [4:0]  int_raddr;
  logic [63:0] int_rdata = '0;
  logic        cr_ren;
  logic [6:0]  cr_raddr;
  logic [3:0]  cr_rdata = '0;
  logic        msk_valid;
  logic        msk_ready = 1'b0;
  logic [63:0] src_mask, dst_mask;

  logic [63:0] iregs [32];
  logic [3:0]  cregs [128];
  logic [4:0]  ilog [256];
  logic [6:0]  clog [256];
  int          int_n = 0;
  int          cr_n = 0;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  pred_mask_fetch u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_src_sel(req_src_sel), .req_dst_sel(req_dst_sel),
    .req_vlen(req_vlen), .req_cr_base(req_cr_base),
    .int_ren(int_ren), .int_raddr(int_raddr), .int_rdata(int_rdata),
    .cr_ren(cr_ren), .cr_raddr(cr_raddr), .cr_rdata(cr_rdata),
    .msk_valid(msk_valid), .msk_ready(msk_ready),
    .src_mask(src_mask), .dst_mask(dst_mask)
  );

  // behavioural register files with one-cycle read latency and read logs
  always @(posedge clk) begin
    if (int_ren) begin
      int_rdata <= iregs[int_raddr];
      ilog[int_n % 256] <= int_raddr;
      int_n <= int_n + 1;
    end
    if (cr_ren) begin
      cr_rdata <= cregs[cr_raddr];
      clog[cr_n % 256] <= cr_raddr;
      cr_n <= cr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int reg_of(input int code);
    if (code <= 3) return 3;
    if (code <= 5) return 10;
    return 30;
  endfunction

  function automatic logic [63:0] exp_int(input int code);
    logic [63:0] v;
    if (code == 0) return {64{1'b1}};
    v = iregs[reg_of(code)];
    if (code == 1) begin
      logic [63:0] r = '0;
      r[v % 64] = 1'b1;
      return r;
    end
    return (code % 2 == 1) ? ~v : v;
  endfunction

  function automatic logic [63:0] exp_cr(input int code, input int vl, input int base);
    logic [63:0] m = '0;
    int n = (vl > 64) ? 64 : vl;
    for (int i = 0; i < n; i++) begin
      logic [3:0] f = cregs[(base + i) % 128];
      logic b = f[code / 2];
      m[i] = (code % 2 == 0) ? b : !b;
    end
    return m;
  endfunction

  task automatic do_req(input int mode, input int s, input int d,
                        input int vl, input int base, input int hold);
    int i0, c0, wait_n, n_exp, k;
    logic [63:0] es, ed, hs, hd;
    string tag;
    bit ok;
    i0 = int_n;
    c0 = cr_n;
    if (mode == 1)      tag = (s == 1 || d == 1) ? "R6" : "R5";
    else if (mode == 2) tag = "R8/R9";
    else                tag = "R4";
    if (mode == 1) begin es = exp_int(s); ed = exp_int(d); end
    else if (mode == 2) begin es = exp_cr(s, vl, base); ed = exp_cr(d, vl, base); end
    else begin es = '1; ed = '1; end
    hs = src_mask;
    hd = dst_mask;

    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready when idle", 64'(req_ready), 64'd1);
    req_mode = mode[1:0]; req_src_sel = s[2:0]; req_dst_sel = d[2:0];
    req_vlen = vl[6:0]; req_cr_base = base[6:0]; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_mode = 2'($urandom); req_src_sel = 3'($urandom); req_dst_sel = 3'($urandom);
    chk(src_mask === hs && dst_mask === hd, "R10", "masks kept after accept", src_mask, hs);
    wait_n = 0;
    while (msk_valid !== 1'b1 && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    chk(req_ready === 1'b0, "R2", "not ready while busy", 64'(req_ready), 64'd0);
    chk(src_mask === es, tag, "src mask", src_mask, es);
    chk(dst_mask === ed, tag, "dst mask", dst_mask, ed);

    // read port behaviour
    if (mode == 1) begin
      n_exp = (s != 0) + (d != 0);
      ok = (int_n - i0 == n_exp) && (cr_n == c0);
      k = i0;
      if (ok && s != 0) begin ok = (ilog[k % 256] == 5'(reg_of(s))); k++; end
      if (ok && d != 0) ok = (ilog[k % 256] == 5'(reg_of(d)));
      chk(ok, "R7", "integer read sequence", 64'(int_n - i0), 64'(n_exp));
    end else if (mode == 2) begin
      n_exp = (vl > 64) ? 64 : vl;
      ok = (cr_n - c0 == n_exp) && (int_n == i0);
      for (int j = 0; j < n_exp; j++)
        if (ok && clog[(c0 + j) % 256] != 7'((base + j) % 128)) ok = 1'b0;
      chk(ok, "R9", "condition read sequence", 64'(cr_n - c0), 64'(n_exp));
    end else begin
      chk(int_n == i0 && cr_n == c0, "R4", "no reads",
          64'((int_n - i0) + (cr_n - c0)), 64'd0);
    end

    for (int h = 0; h < hold; h++) @(negedge clk);
    chk(msk_valid === 1'b1 && src_mask === es && dst_mask === ed, "R3",
        "result held under stall", src_mask, es);
    msk_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msk_ready = 1'b0;
    chk(req_ready === 1'b1 && msk_valid === 1'b0, "R3", "back to idle",
        64'({req_ready, msk_valid}), 64'b10);
    @(negedge clk);
    @(negedge clk);
    chk(src_mask === es && dst_mask === ed, "R10", "masks stable while idle", dst_mask, ed);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) iregs[i] = {$urandom, $urandom};
    for (int i = 0; i < 128; i++) cregs[i] = 4'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && msk_valid === 1'b0, "R1", "reset handshake",
        64'({req_ready, msk_valid}), 64'b10);
    chk(src_mask === '0 && dst_mask === '0, "R1", "reset masks", src_mask, 64'd0);
    chk(!int_ren && !cr_ren, "R1", "no read after reset", 64'({int_ren, cr_ren}), 64'd0);

    // directed corners
    do_req(0, 5, 2, 10, 0, 0);                          // R4 none
    do_req(3, 7, 1, 10, 0, 2);                          // R4 reserved mode
    do_req(1, 0, 0, 0, 0, 1);                           // R5 always, no reads
    iregs[3] = 64'd70;                                  // R6 unary wraps to bit 6
    do_req(1, 1, 0, 0, 0, 0);
    iregs[3] = 64'd63;
    do_req(1, 3, 1, 0, 0, 3);                           // R6 top bit
    for (int c = 2; c < 8; c++) do_req(1, c, 9 - c, 0, 0, c % 3); // R5 table
    do_req(2, 0, 1, 0, 5, 0);                           // R9 zero length
    do_req(2, 2, 3, 64, 100, 1);                        // R9 full length, wrap
    do_req(2, 4, 7, 100, 127, 0);                       // R9 clamp
    do_req(2, 6, 5, 1, 127, 2);                         // R8 single element

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int m = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) iregs[3] = 64'($urandom_range(0, 200));
      else iregs[3] = {$urandom, $urandom};
      iregs[10] = {$urandom, $urandom};
      iregs[30] = {$urandom, $urandom};
      for (int i = 0; i < 8; i++) cregs[$urandom_range(0, 127)] = 4'($urandom);
      do_req(m, $urandom_range(0, 7), $urandom_range(0, 7),
             $urandom_range(0, 127), $urandom_range(0, 127), $urandom_range(0, 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule